// File: doc/BRIEF.md
# Serial Ones-Complement Adder/Subtracter

This block adds or subtracts two 4-bit ones-complement numbers one bit per clock. It uses a single full adder. Two operand shift registers, X and Y, present their least significant bit to the adder. Each sum bit is written back into the top of X, so X ends the operation holding the result. Y is rotated through itself and comes back unchanged. A mode pin selects the operation. In add mode the block forms X+Y. In subtract mode it forms X−Y by feeding the inverted Y bits to the adder.

Ones-complement arithmetic needs the carry out of the top bit added back in at the bottom. The block does this with a second pass over X, so every operation takes two full passes, eight shifts in all:

- In the first pass the raw sum goes into X, and the carry flip-flop keeps the carry out of the top bit.
- In the second pass the Y input is masked to zero. The saved carry enters as carry-in and ripples through X.

A three-state controller (idle, shifting, finished) sequences the work. A shift counter raises its terminal flag on the last shift.

Operands enter through a valid/ready load port. `load_ready` is high only while the block is idle. A beat is taken on a clock edge where both `load_valid` and `load_ready` are high. While the block is shifting or finished, `load_ready` is low and the beat is held off. The result is not a stream: `x_out` simply holds the accumulator. `start` is a plain level. Once an operation has finished, `done` stays high for as long as `start` stays high. A new operation needs `start` to go low and then high again.

Top module: `serial_oc_addsub`

## Requirements
- R1: After reset, `x_out` and `y_out` are 0, `busy` and `done` are 0 and `load_ready` is 1.
- R2: `load_ready` is 1 exactly while the block is idle. A load (`load_valid`=1 and `load_ready`=1 on a clock edge) copies `x_load` into X and `y_load` into Y.
- R3: With `mode_add`=1, the finished `x_out` equals the ones-complement sum. This is ((x+y) mod 16 + (x+y) div 16) mod 16.
- R4: With `mode_add`=0, the finished `x_out` equals x minus y. This is computed as the R3 formula with y replaced by (15−y), the bitwise inverse of y.
- R5: Suppose `start` is sampled high on an edge while the block is idle. Then `busy` is high for exactly the next 8 cycles. `done` rises on the 8th edge after the launch edge.
- R6: When `done` rises, `y_out` equals the Y value held at launch.
- R7: While `done` is high and `start` stays high, the block stays finished and does not shift again. After `start` is sampled low in the finished state, the next edge returns the block to idle.
- R8: A load offered while `busy` or `done` is high is ignored. The result in `x_out` is unaffected, and `x_out` changes in no cycle outside a shift or an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start level; must return low before the next operation |
| mode_add | input | 1 | 1 = X+Y, 0 = X−Y; held constant during an operation |
| load_valid | input | 1 | Operand load request |
| load_ready | output | 1 | High while idle; a load is taken when both are high |
| x_load | input | 4 | Parallel value for X |
| y_load | input | 4 | Parallel value for Y |
| x_out | output | 4 | Accumulator X (the result after `done`) |
| y_out | output | 4 | Operand register Y |
| busy | output | 1 | Shift enable; high during each of the 8 shifts |
| done | output | 1 | Operation finished; held until `start` is low |

## Verification
The bench runs all 256 operand pairs in both modes. It compares each result with an arithmetic ones-complement model. This separates a missing or misplaced end-around carry, which only shows when the raw sum overflows, from a wrong inversion of Y in subtract mode. It also catches a Y input that leaks into the second pass, which only shows when Y is nonzero. A few runs keep `start` high through the finished state. Others offer loads in the middle of a run, to show that the block neither restarts nor takes a load while it is working. The edges on which `busy` and `done` change are checked against a count of exactly eight shifts.

// File: rtl/soa_pkg.sv
package soa_pkg;
  typedef enum logic [1:0] {
    SOA_IDLE  = 2'd0,
    SOA_SHIFT = 2'd1,
    SOA_DONE  = 2'd2
  } soa_state_e;
endpackage

// File: rtl/soa_ctrl.sv
module soa_ctrl
  import soa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic launch,
  output logic sh,
  output logic idle,
  output logic fin
);
  soa_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SOA_IDLE:  if (start) st_d = SOA_SHIFT;
      SOA_SHIFT: if (last)  st_d = SOA_DONE;
      SOA_DONE:  if (!start) st_d = SOA_IDLE;
      default:   st_d = SOA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SOA_IDLE;
    else        st_q <= st_d;
  end

  assign idle   = (st_q == SOA_IDLE);
  assign sh     = (st_q == SOA_SHIFT);
  assign fin    = (st_q == SOA_DONE);
  assign launch = idle && start;
endmodule

// File: rtl/soa_counter.sv
module soa_counter #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last,
  output logic second_pass
);
  localparam int SHIFTS = 2 * WIDTH;
  localparam int CNT_W  = $clog2(SHIFTS);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(SHIFTS - 1);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(WIDTH);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
  end

  assign last        = (cnt_q == LAST_V);
  assign second_pass = (cnt_q >= HALF_V);
endmodule

// File: rtl/soa_shreg.sv
module soa_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] par_in,
  input  logic             shift,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_r;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic nxt;
    if (i == WIDTH - 1) begin : g_top
      assign nxt = ser_in;
    end else begin : g_mid
      assign nxt = q_r[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_r[i] <= 1'b0;
      else if (load)  q_r[i] <= par_in[i];
      else if (shift) q_r[i] <= nxt;
    end
  end

  assign q       = q_r;
  assign ser_out = q_r[0];
endmodule

// File: rtl/soa_operand.sv
module soa_operand (
  input  logic y_bit,
  input  logic add_mode,
  input  logic mask,
  output logic b_bit
);
  always_comb begin
    if (mask)          b_bit = 1'b0;
    else if (add_mode) b_bit = y_bit;
    else               b_bit = ~y_bit;
  end
endmodule

// File: rtl/serial_oc_addsub.sv
module serial_oc_addsub #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_add,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [WIDTH-1:0] x_load,
  input  logic [WIDTH-1:0] y_load,
  output logic [WIDTH-1:0] x_out,
  output logic [WIDTH-1:0] y_out,
  output logic             busy,
  output logic             done
);
  logic launch, sh, idle, fin, last, second_pass;
  logic take;
  logic x_bit, y_bit, b_bit, sum_bit, cout, carry_q;

  soa_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last),
    .launch(launch), .sh(sh), .idle(idle), .fin(fin)
  );

  soa_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(launch), .en(sh),
    .last(last), .second_pass(second_pass)
  );

  assign take = load_valid && idle;

  soa_shreg #(.WIDTH(WIDTH)) u_x (
    .clk(clk), .rst_n(rst_n), .load(take), .par_in(x_load),
    .shift(sh), .ser_in(sum_bit), .ser_out(x_bit), .q(x_out)
  );

  soa_shreg #(.WIDTH(WIDTH)) u_y (
    .clk(clk), .rst_n(rst_n), .load(take), .par_in(y_load),
    .shift(sh), .ser_in(y_bit), .ser_out(y_bit), .q(y_out)
  );

  soa_operand u_op (
    .y_bit(y_bit), .add_mode(mode_add), .mask(second_pass), .b_bit(b_bit)
  );

  // one full adder shared by both passes
  assign sum_bit = x_bit ^ b_bit ^ carry_q;
  assign cout    = (x_bit & b_bit) | (carry_q & (x_bit ^ b_bit));

  // carry is kept across the pass boundary: it becomes the end-around carry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      carry_q <= 1'b0;
    else if (launch) carry_q <= 1'b0;
    else if (sh)     carry_q <= cout;
  end

  assign load_ready = idle;
  assign busy       = sh;
  assign done       = fin;
endmodule

// File: rtl/soa_checker.sv
module soa_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             mode_add,
  input logic             load_valid,
  input logic             load_ready,
  input logic [WIDTH-1:0] x_load,
  input logic [WIDTH-1:0] y_load,
  input logic [WIDTH-1:0] x_out,
  input logic [WIDTH-1:0] y_out,
  input logic             busy,
  input logic             done
);
  logic [7:0]       run_len;
  logic             busy_q;
  logic [WIDTH-1:0] y_snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      busy_q  <= 1'b0;
      y_snap  <= '0;
    end else begin
      run_len <= busy ? run_len + 8'd1 : 8'd0;
      busy_q  <= busy;
      if (busy && !busy_q) y_snap <= y_out;
    end
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |-> (!busy && !done)); // R2
  AST_EIGHT_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (run_len == 8'(2 * WIDTH))); // R5
  AST_Y_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (y_out == y_snap)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (done && !busy)); // R7
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!done && load_ready)); // R7
  AST_X_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(load_valid && load_ready)) |=> $stable(x_out)); // R8
endmodule

bind serial_oc_addsub soa_checker #(.WIDTH(WIDTH)) u_soa_chk (.*);

// File: tb/serial_oc_addsub_test.sv
module serial_oc_addsub_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mode_add = 1'b1;
  logic       load_valid = 1'b0;
  logic       load_ready;
  logic [3:0] x_load = '0;
  logic [3:0] y_load = '0;
  logic [3:0] x_out, y_out;
  logic       busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_oc_addsub #(.WIDTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_add(mode_add),
    .load_valid(load_valid), .load_ready(load_ready),
    .x_load(x_load), .y_load(y_load), .x_out(x_out), .y_out(y_out),
    .busy(busy), .done(done)
  );

  function automatic logic [3:0] ref_oc(input logic [3:0] x, input logic [3:0] y,
                                        input logic add);
    int b, s;
    b = add ? int'(y) : 15 - int'(y);
    s = int'(x) + b;
    return 4'(((s % 16) + (s / 16)) % 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one full operation; load and start offered on the same edge
  task automatic run_op(input logic [3:0] x, input logic [3:0] y, input logic add,
                        input bit hold, input bit inject);
    logic [3:0] exp;
    exp = ref_oc(x, y, add);
    @(negedge clk);
    chk(load_ready == 1'b1, "R2", int'(load_ready), 1);
    x_load = x; y_load = y; mode_add = add;
    load_valid = 1'b1; start = 1'b1;
    @(posedge clk);               // launch edge
    @(negedge clk);
    chk(x_out == x && y_out == y, "R2", int'(x_out), int'(x));
    load_valid = inject;
    x_load = ~x; y_load = ~y;
    if (!hold) start = 1'b0;
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0, "R5", int'(done), 0);
    if (inject) chk(load_ready == 1'b0, "R2", int'(load_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R5", int'(done), 1);
    chk(x_out == exp, add ? "R3" : "R4", int'(x_out), int'(exp));
    chk(y_out == y, "R6", int'(y_out), int'(y));
    if (inject) chk(x_out == exp, "R8", int'(x_out), int'(exp));
    if (hold) begin
      repeat (3) begin
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0 && x_out == exp, "R7", int'(x_out), int'(exp));
      end
      start = 1'b0;
      load_valid = 1'b0;
      @(negedge clk);
      chk(load_ready == 1'b1 && done == 1'b0, "R7", int'(done), 0);
      chk(x_out == exp, "R8", int'(x_out), int'(exp));
    end else begin
      load_valid = 1'b0;
      @(negedge clk);
      chk(done == 1'b0 && load_ready == 1'b1, "R7", int'(done), 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(x_out == 4'd0 && y_out == 4'd0, "R1", int'(x_out), 0);
    chk(busy == 1'b0 && done == 1'b0 && load_ready == 1'b1, "R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // idle with no load: x_out must stay put
    chk(x_out == 4'd0, "R8", int'(x_out), 0);

    for (int m = 0; m < 2; m++) begin
      for (int xi = 0; xi < 16; xi++) begin
        for (int yi = 0; yi < 16; yi++) begin
          run_op(4'(xi), 4'(yi), m[0], 1'b0, 1'b0);
        end
      end
    end

    // start held through the finished state, loads offered mid-run
    run_op(4'd7, 4'd9, 1'b1, 1'b1, 1'b1);   // end-around carry case, R3
    run_op(4'd3, 4'd3, 1'b0, 1'b1, 1'b1);   // x - x gives negative zero, R4
    run_op(4'd15, 4'd15, 1'b1, 1'b1, 1'b0); // R7
    run_op(4'd12, 4'd5, 1'b0, 1'b0, 1'b1);  // R8

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule